// File: doc/BRIEF.md
# Peripheral Request Flag Unit for a DMA Thread

This block connects up to four peripheral channels to a DMA engine. Each peripheral raises a request with a 2-bit type and a last indicator. The request inputs are not timed to the DMA clock, so every one of them passes through a synchronizer first. When a DMA thread is halted waiting for a given channel, the block takes that channel's request and turns it into two flags: the transfer kind (single or burst) and the last marker. The peripheral therefore decides how long a transfer is. The thread may also name an explicit single or burst qualifier in its wait, and the qualifier then takes precedence over whatever the peripheral drives.

In the other direction, the engine reports that a transaction has completed on a channel. The block raises an acknowledge-valid toward that peripheral, carrying a 2-bit completion code, and holds it until the peripheral's acknowledge-ready comes back through its own synchronizer. Both directions use a four-phase valid/ready exchange.

Top module: `dma_periph_req_if`

## Requirements
- R1: A request valid is only seen after SYNC_STAGES (default 2) clock edges of synchronization. With a waiting thread, `req_ready` falls on the edge after those, which is the third edge after valid rises at the default depth.
- R2: A channel's request is captured only while `wait_en` is 1 and `wait_ch` equals that channel. Otherwise `req_ready` stays 1 and that channel's flags keep their values.
- R3: With `wait_qual` = 00 (no qualifier), a request type of 01 sets `flag_burst` to 1. Types 00, 10 and 11 set it to 0 (single).
- R4: With `wait_qual` = 00, `flag_last` takes the value of the channel's last input at capture.
- R5: With `wait_qual` = 01, `flag_burst` is forced to 0. With `wait_qual` = 10, it is forced to 1. In both cases `flag_last` is forced to 0. The code 11 behaves like 00.
- R6: `req_ready` of a channel falls the cycle after a capture. It stays 0 until the synchronized valid is seen low, and then returns to 1.
- R7: `wait_done` is a one-cycle pulse in the cycle after a capture.
- R8: A `done_req` for a channel with no acknowledge in progress sets `ack_valid` and loads `ack_type` with `done_code` on the next cycle. Both are held until the synchronized `ack_ready` is 1. `ack_valid` then drops, and no new acknowledge starts until `ack_ready` has been seen low.
- R9: A `done_req` for a channel whose acknowledge is still in progress is ignored. `ack_type` is not changed.
- R10: A synchronous active-high reset sets every `req_ready` to 1 and clears all flags, `wait_done`, every `ack_valid` and every `ack_type`.
- R11: The channels are independent. A request or acknowledge on one channel leaves the outputs of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DMA clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_CH | Per-channel request valid (asynchronous) |
| req_type | input | 2*NUM_CH | Per-channel request type, 2 bits per channel (asynchronous) |
| req_last | input | NUM_CH | Per-channel last indicator (asynchronous) |
| req_ready | output | NUM_CH | Per-channel request ready |
| wait_en | input | 1 | Thread is halted waiting for a peripheral |
| wait_ch | input | CHW | Channel the thread waits on |
| wait_qual | input | 2 | Wait qualifier: 00 none, 01 single, 10 burst, 11 none |
| wait_done | output | 1 | Pulse: the waited-for request was captured |
| flag_burst | output | NUM_CH | Latched request kind per channel (1 = burst) |
| flag_last | output | NUM_CH | Latched last flag per channel |
| done_req | input | 1 | Engine reports a completed transaction |
| done_ch | input | CHW | Channel of the completed transaction |
| done_code | input | 2 | Completion code to return |
| ack_valid | output | NUM_CH | Per-channel acknowledge valid |
| ack_type | output | 2*NUM_CH | Per-channel acknowledge code |
| ack_ready | input | NUM_CH | Per-channel acknowledge ready (asynchronous) |

## Verification
The hardest cases to reach from the ports are a completion report that arrives while the same channel's acknowledge is still in progress, and a request that is valid while the thread waits on a different channel. The stimulus keeps `ack_ready` low across a second `done_req`, and issues another one during the drain phase. It raises a request on one channel while `wait_en` is off and then while `wait_ch` points elsewhere, and observes ready and the flags before it enables the match. A behavioural reference model with its own synchronizer delays is compared with every output on every cycle.

// File: rtl/dma_prq_pkg.sv
package dma_prq_pkg;

    typedef enum logic [1:0] {
        QUAL_NONE   = 2'b00,
        QUAL_SINGLE = 2'b01,
        QUAL_BURST  = 2'b10,
        QUAL_RSVD   = 2'b11
    } wfp_qual_e;

    typedef enum logic {
        KIND_SINGLE = 1'b0,
        KIND_BURST  = 1'b1
    } req_kind_e;

    typedef struct packed {
        req_kind_e kind;
        logic      last;
    } req_flags_t;

    typedef enum logic {
        RQ_OPEN = 1'b0,
        RQ_HELD = 1'b1
    } req_state_e;

    typedef enum logic [1:0] {
        AK_IDLE   = 2'b00,
        AK_ACTIVE = 2'b01,
        AK_DRAIN  = 2'b10
    } ack_state_e;

    localparam int TYPE_W = 2;
    localparam int CODE_W = 2;

    function automatic req_kind_e decode_kind(input logic [TYPE_W-1:0] t);
        return (t == 2'b01) ? KIND_BURST : KIND_SINGLE;
    endfunction

    function automatic req_flags_t resolve_flags(input wfp_qual_e q,
                                                 input logic [TYPE_W-1:0] t,
                                                 input logic l);
        req_flags_t f;
        case (q)
            QUAL_SINGLE: begin f.kind = KIND_SINGLE; f.last = 1'b0; end
            QUAL_BURST:  begin f.kind = KIND_BURST;  f.last = 1'b0; end
            default:     begin f.kind = decode_kind(t); f.last = l; end
        endcase
        return f;
    endfunction

endpackage

// File: rtl/prq_sync.sv
module prq_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/prq_req_chan.sv
module prq_req_chan
    import dma_prq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_s,
    input  logic [TYPE_W-1:0] type_s,
    input  logic              last_s,
    input  logic              sel,
    input  wfp_qual_e         qual,
    output logic              ready,
    output req_flags_t        flags,
    output logic              capture
);
    req_state_e st;

    assign capture = (st == RQ_OPEN) && valid_s && sel;
    assign ready   = (st == RQ_OPEN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RQ_OPEN;
            flags <= '0;
        end else begin
            case (st)
                RQ_OPEN: if (capture) begin
                    st    <= RQ_HELD;
                    flags <= resolve_flags(qual, type_s, last_s);
                end
                RQ_HELD: if (!valid_s) st <= RQ_OPEN;
                default: st <= RQ_OPEN;
            endcase
        end
    end

    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (rst)
        capture |=> !ready);
    assert_hold_until_release_R6: assert property (@(posedge clk) disable iff (rst)
        (!ready && valid_s) |=> !ready);
    assert_flags_stable_R2: assert property (@(posedge clk) disable iff (rst)
        !capture |=> $stable(flags));
    assert_override_last_R5: assert property (@(posedge clk) disable iff (rst)
        (capture && (qual == QUAL_SINGLE || qual == QUAL_BURST)) |=> !flags.last);
endmodule

// File: rtl/prq_ack_chan.sv
module prq_ack_chan
    import dma_prq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CODE_W-1:0] code,
    input  logic              rdy_s,
    output logic              ack_valid,
    output logic [CODE_W-1:0] ack_type
);
    ack_state_e st;

    assign ack_valid = (st == AK_ACTIVE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= AK_IDLE;
            ack_type <= '0;
        end else begin
            case (st)
                AK_IDLE:   if (start) begin
                    st       <= AK_ACTIVE;
                    ack_type <= code;
                end
                AK_ACTIVE: if (rdy_s)  st <= AK_DRAIN;
                AK_DRAIN:  if (!rdy_s) st <= AK_IDLE;
                default:   st <= AK_IDLE;
            endcase
        end
    end

    assert_ack_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (ack_valid && !rdy_s) |=> (ack_valid && $stable(ack_type)));
    assert_busy_ignore_R9: assert property (@(posedge clk) disable iff (rst)
        (st != AK_IDLE) |=> $stable(ack_type));
endmodule

// File: rtl/dma_periph_req_if.sv
module dma_periph_req_if
    import dma_prq_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int CHW         = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [NUM_CH-1:0]        req_valid,
    input  logic [2*NUM_CH-1:0]      req_type,
    input  logic [NUM_CH-1:0]        req_last,
    output logic [NUM_CH-1:0]        req_ready,
    input  logic                     wait_en,
    input  logic [CHW-1:0]           wait_ch,
    input  logic [1:0]               wait_qual,
    output logic                     wait_done,
    output logic [NUM_CH-1:0]        flag_burst,
    output logic [NUM_CH-1:0]        flag_last,
    input  logic                     done_req,
    input  logic [CHW-1:0]           done_ch,
    input  logic [1:0]               done_code,
    output logic [NUM_CH-1:0]        ack_valid,
    output logic [2*NUM_CH-1:0]      ack_type,
    input  logic [NUM_CH-1:0]        ack_ready
);
    localparam int SYNC_W = TYPE_W + 3;

    wfp_qual_e          qual;
    logic [NUM_CH-1:0]  cap;

    assign qual = wfp_qual_e'(wait_qual);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic [SYNC_W-1:0] raw, synced;
        req_flags_t        fl;

        assign raw = {ack_ready[i], req_last[i], req_type[2*i +: 2], req_valid[i]};

        prq_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (raw),
            .q   (synced)
        );

        prq_req_chan u_req (
            .clk     (clk),
            .rst     (rst),
            .valid_s (synced[0]),
            .type_s  (synced[2:1]),
            .last_s  (synced[3]),
            .sel     (wait_en && (wait_ch == CHW'(i))),
            .qual    (qual),
            .ready   (req_ready[i]),
            .flags   (fl),
            .capture (cap[i])
        );

        assign flag_burst[i] = (fl.kind == KIND_BURST);
        assign flag_last[i]  = fl.last;

        prq_ack_chan u_ack (
            .clk       (clk),
            .rst       (rst),
            .start     (done_req && (done_ch == CHW'(i))),
            .code      (done_code),
            .rdy_s     (synced[4]),
            .ack_valid (ack_valid[i]),
            .ack_type  (ack_type[2*i +: 2])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) wait_done <= 1'b0;
        else     wait_done <= |cap;
    end

    assert_single_capture_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cap));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        (|cap) |=> wait_done);
    assert_done_needs_capture_R7: assert property (@(posedge clk) disable iff (rst)
        (cap == '0) |=> !wait_done);
endmodule

// File: tb/dma_periph_req_if_bench.sv
module dma_periph_req_if_bench;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NCH-1:0]   pv = '0, pl = '0, ar = '0;
    logic [2*NCH-1:0] pt = '0;
    logic             w_en = 1'b0, d_req = 1'b0;
    logic [1:0]       w_ch = '0, w_q = '0, d_ch = '0, d_code = '0;

    logic [NCH-1:0]   req_ready, flag_burst, flag_last, ack_valid;
    logic [2*NCH-1:0] ack_type;
    logic             wait_done;

    always #5 clk = ~clk;

    dma_periph_req_if u_dma_periph_req_if (
        .clk(clk), .rst(rst),
        .req_valid(pv), .req_type(pt), .req_last(pl), .req_ready(req_ready),
        .wait_en(w_en), .wait_ch(w_ch), .wait_qual(w_q), .wait_done(wait_done),
        .flag_burst(flag_burst), .flag_last(flag_last),
        .done_req(d_req), .done_ch(d_ch), .done_code(d_code),
        .ack_valid(ack_valid), .ack_type(ack_type), .ack_ready(ar)
    );

    int n_chk = 0, n_fail = 0;
    bit cmp_on = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model
    int s1v[NCH], s2v[NCH], s1t[NCH], s2t[NCH], s1l[NCH], s2l[NCH], s1a[NCH], s2a[NCH];
    int held[NCH], m_burst[NCH], m_last[NCH], ak[NCH], m_atype[NCH];
    int m_done;

    always @(posedge clk) begin
        if (rst) begin
            m_done = 0;
            for (int c = 0; c < NCH; c++) begin
                s1v[c] = 0; s2v[c] = 0; s1t[c] = 0; s2t[c] = 0;
                s1l[c] = 0; s2l[c] = 0; s1a[c] = 0; s2a[c] = 0;
                held[c] = 0; m_burst[c] = 0; m_last[c] = 0; ak[c] = 0; m_atype[c] = 0;
            end
        end else begin
            int got;
            got = 0;
            for (int c = 0; c < NCH; c++) begin
                if (held[c] == 0) begin
                    if (s2v[c] != 0 && w_en && int'(w_ch) == c) begin
                        got = 1;
                        held[c] = 1;
                        if (w_q == 2'b01)      begin m_burst[c] = 0; m_last[c] = 0; end
                        else if (w_q == 2'b10) begin m_burst[c] = 1; m_last[c] = 0; end
                        else begin m_burst[c] = (s2t[c] == 1) ? 1 : 0; m_last[c] = s2l[c]; end
                    end
                end else if (s2v[c] == 0) held[c] = 0;
                if (ak[c] == 0) begin
                    if (d_req && int'(d_ch) == c) begin ak[c] = 1; m_atype[c] = int'(d_code); end
                end else if (ak[c] == 1) begin
                    if (s2a[c] != 0) ak[c] = 2;
                end else if (s2a[c] == 0) ak[c] = 0;
                s2v[c] = s1v[c]; s1v[c] = int'(pv[c]);
                s2t[c] = s1t[c]; s1t[c] = int'(pt[2*c +: 2]);
                s2l[c] = s1l[c]; s1l[c] = int'(pl[c]);
                s2a[c] = s1a[c]; s1a[c] = int'(ar[c]);
            end
            m_done = got;
        end
    end

    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R7", "model wait_done", int'(wait_done), m_done);
            for (int c = 0; c < NCH; c++) begin
                chk("R6", $sformatf("model ready ch%0d", c), int'(req_ready[c]), held[c] == 0 ? 1 : 0);
                chk("R3", $sformatf("model burst ch%0d", c), int'(flag_burst[c]), m_burst[c]);
                chk("R4", $sformatf("model last ch%0d", c), int'(flag_last[c]), m_last[c]);
                chk("R8", $sformatf("model ack_valid ch%0d", c), int'(ack_valid[c]), ak[c] == 1 ? 1 : 0);
                chk("R8", $sformatf("model ack_type ch%0d", c), int'(ack_type[2*c +: 2]), m_atype[c]);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic raise_req(input int c, input logic [1:0] t, input logic l);
        pt[2*c +: 2] = t; pl[c] = l; pv[c] = 1'b1;
    endtask

    task automatic do_wait(input int c, input logic [1:0] q);
        w_en = 1'b1; w_ch = 2'(c); w_q = q;
    endtask

    task automatic pulse_done(input int c, input logic [1:0] code);
        d_req = 1'b1; d_ch = 2'(c); d_code = code;
        step(1);
        d_req = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        step(1); step(2);
        rst = 1'b0;
        cmp_on = 1;
        // R10 reset state
        chk("R10", "ready after reset", int'(req_ready), 15);
        chk("R10", "burst after reset", int'(flag_burst), 0);
        chk("R10", "last after reset", int'(flag_last), 0);
        chk("R10", "ack_valid after reset", int'(ack_valid), 0);
        chk("R10", "ack_type after reset", int'(ack_type), 0);
        chk("R10", "wait_done after reset", int'(wait_done), 0);

        // R1 / R3 burst request on ch0
        do_wait(0, 2'b00);
        raise_req(0, 2'b01, 1'b0);
        step(2);
        chk("R1", "ready before sync done", int'(req_ready[0]), 1);
        step(1);
        chk("R6", "ready drops after capture", int'(req_ready[0]), 0);
        chk("R7", "wait_done pulse", int'(wait_done), 1);
        chk("R3", "type 01 is burst", int'(flag_burst[0]), 1);
        w_en = 1'b0;
        step(1);
        chk("R7", "wait_done single cycle", int'(wait_done), 0);
        pv[0] = 1'b0;
        step(2);
        chk("R6", "ready low until release synced", int'(req_ready[0]), 0);
        step(1);
        chk("R6", "ready back after release", int'(req_ready[0]), 1);

        // R3 / R4 single with last on ch1
        do_wait(1, 2'b00);
        raise_req(1, 2'b00, 1'b1);
        step(3);
        chk("R3", "type 00 is single", int'(flag_burst[1]), 0);
        chk("R4", "last follows input", int'(flag_last[1]), 1);
        chk("R11", "ch0 flags untouched", int'(flag_burst[0]), 1);
        w_en = 1'b0; pv[1] = 1'b0; step(4);

        // R3 reserved code on ch2
        do_wait(2, 2'b00);
        raise_req(2, 2'b11, 1'b0);
        step(3);
        chk("R3", "type 11 is single", int'(flag_burst[2]), 0);
        w_en = 1'b0; pv[2] = 1'b0; step(4);

        // R2 no capture while not waiting, or waiting elsewhere
        raise_req(3, 2'b01, 1'b1);
        step(5);
        chk("R2", "ready high without wait", int'(req_ready[3]), 1);
        chk("R2", "flags unchanged without wait", int'(flag_burst[3]), 0);
        do_wait(1, 2'b00);
        step(3);
        chk("R2", "ready high when other channel waited", int'(req_ready[3]), 1);
        chk("R2", "last unchanged when other channel waited", int'(flag_last[3]), 0);
        do_wait(3, 2'b00);
        step(1);
        chk("R2", "captured once selected", int'(req_ready[3]), 0);
        chk("R4", "last captured ch3", int'(flag_last[3]), 1);
        w_en = 1'b0; pv[3] = 1'b0; step(4);

        // R5 overrides
        do_wait(0, 2'b10);
        raise_req(0, 2'b00, 1'b1);
        step(3);
        chk("R5", "burst qualifier forces burst", int'(flag_burst[0]), 1);
        chk("R5", "qualifier clears last", int'(flag_last[0]), 0);
        w_en = 1'b0; pv[0] = 1'b0; step(4);
        do_wait(0, 2'b01);
        raise_req(0, 2'b01, 1'b1);
        step(3);
        chk("R5", "single qualifier forces single", int'(flag_burst[0]), 0);
        chk("R5", "single qualifier clears last", int'(flag_last[0]), 0);
        w_en = 1'b0; pv[0] = 1'b0; step(4);

        // R8 / R9 acknowledge on ch1
        pulse_done(1, 2'b10);
        chk("R8", "ack_valid set", int'(ack_valid[1]), 1);
        chk("R8", "ack_type loaded", int'(ack_type[3:2]), 2);
        pulse_done(1, 2'b01);
        step(1);
        chk("R9", "busy done ignored", int'(ack_type[3:2]), 2);
        chk("R8", "ack held without ready", int'(ack_valid[1]), 1);
        ar[1] = 1'b1;
        step(2);
        chk("R8", "ack held until ready synced", int'(ack_valid[1]), 1);
        step(1);
        chk("R8", "ack drops after ready", int'(ack_valid[1]), 0);
        pulse_done(1, 2'b11);
        chk("R9", "done during drain ignored", int'(ack_valid[1]), 0);
        chk("R9", "type kept during drain", int'(ack_type[3:2]), 2);
        ar[1] = 1'b0;
        step(3);
        pulse_done(1, 2'b01);
        chk("R8", "new ack after release", int'(ack_type[3:2]), 1);
        ar[1] = 1'b1; step(4); ar[1] = 1'b0; step(4);

        // R11 concurrent request and acknowledge on different channels
        do_wait(2, 2'b00);
        raise_req(2, 2'b01, 1'b1);
        pulse_done(3, 2'b11);
        chk("R11", "ack on ch3 only", int'(ack_valid), 8);
        step(2);
        chk("R11", "ch2 captured independently", int'(flag_burst[2]), 1);
        chk("R11", "ch1 ready unaffected", int'(req_ready[1]), 1);
        w_en = 1'b0; pv[2] = 1'b0; ar[3] = 1'b1; step(5); ar[3] = 1'b0; step(5);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule